// File: doc/BRIEF.md
# Kickstart Power-On Controller

This block owns the active-low enable that switches a system's main supply on and off. It runs from a backup supply, so it stays alive while the main rail is down. While the main rail is absent, two hardware events can bring the system back up: a debounced press on an active-low kickstart input, or a one-cycle wake-up pulse from a neighbouring alarm source. The kickstart path works only when the host has armed it with an auxiliary-battery enable bit. The wake-up path needs no such bit.

Once the main rail is good, the power enable belongs to the host. The host writes a power-off command to drop it. After that, only a fresh kickstart or wake-up event can raise it again. While the rail is good, the kickstart input stops acting as a power request and instead sets a sticky interrupt flag. That flag can drive an active-low interrupt line. Supply sensing is reduced to a digital main-power-good input.

Top module: `pwr_kick_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `pwr_en_n` and `irq_n` are 1, the control register reads 0 and the flag register reads 0.
- R2: With `main_pwr_ok`=0 and control bit 0 (auxiliary enable) set, a kickstart press drives `pwr_en_n` to 0. The press is `kick_n` sampled low on DEB_LEN consecutive rising edges. `pwr_en_n` falls after rising edge DEB_LEN+SYNC_STAGES+1, counted from the first edge that samples the low level. It is still 1 after edge DEB_LEN+SYNC_STAGES.
- R3: A low pulse on `kick_n` that spans fewer than DEB_LEN sampling edges causes no power-on and sets no flag.
- R4: With `main_pwr_ok`=0 and control bit 0 clear, a kickstart press leaves `pwr_en_n` at 1.
- R5: With `main_pwr_ok`=0, `wake_evt` high on a rising edge drives `pwr_en_n` to 0 after that edge, whatever the value of control bit 0.
- R6: With `main_pwr_ok`=1, writing 1 to bit 0 of the command register (address 1) sets `pwr_en_n` to 1 after that edge. While the main rail stays good, neither kickstart presses nor `wake_evt` lower it again. After the rail drops, it stays 1 until a new event.
- R7: With `main_pwr_ok`=1, a kickstart press (timed as in R2) sets bit 0 of the flag register (address 2). The flag stays set until the host writes 1 to that bit.
- R8: When a kickstart press sets the flag on the same edge as a write-1-to-clear, the flag ends up set.
- R9: `irq_n` is 0 exactly when the flag is set and control bit 1 (interrupt enable) is set.
- R10: A kickstart press produces one event only. While `kick_n` stays low, a flag cleared after the press stays clear.
- R11: The control register (address 0) reads back all DATA_W bits last written. Bit 0 of the command register reads 1 while power is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock from the backup domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pwr_ok | input | 1 | Main supply good (digital stand-in for sensing) |
| kick_n | input | 1 | Asynchronous active-low kickstart input |
| wake_evt | input | 1 | One-cycle wake-up event, synchronous to clk |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host write address: 0 control, 1 command, 2 flag |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | 2 | Host read address |
| rd_data | output | DATA_W | Combinational read data |
| pwr_en_n | output | 1 | Active-low system power enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with two synchroniser stages and a debounce length of 4. These values put the full press-to-power latency of seven edges inside a short window. They also let a three-cycle glitch land one sample short of a valid press. A behavioural reference model delays each press by the synchroniser depth plus one. The bench then times a flag clear onto the very edge where a new press lands. It also holds the input low across a clear to show that a long press yields only one event.

// File: rtl/pkc_pkg.sv
package pkc_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMD  = 2'd1,
    REG_FLAG = 2'd2
  } pkc_reg_e;

  localparam int CTRL_AUX_BIT   = 0;
  localparam int CTRL_IRQEN_BIT = 1;
  localparam int CMD_OFF_BIT    = 0;
  localparam int FLAG_KICK_BIT  = 0;

  // next power state: host owns it with main good, events own it without
  function automatic logic pkc_next_pwr(input logic main_ok, input logic aux_en,
                                        input logic kick_evt, input logic wake,
                                        input logic off_cmd, input logic cur);
    logic nxt;
    nxt = cur;
    if (main_ok) begin
      if (off_cmd) nxt = 1'b0;
    end else if ((kick_evt && aux_en) || wake) begin
      nxt = 1'b1;
    end
    return nxt;
  endfunction

  // sticky flag, set wins over clear
  function automatic logic pkc_next_flag(input logic set, input logic clr, input logic cur);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/pkc_kick_filter.sv
module pkc_kick_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_n,
  output logic kick_evt_o
);

  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEB_LEN);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(DEB_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       low_cnt_q;
  logic                   lvl_s;
  logic                   evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q[0] <= kick_n;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lvl_s = sync_q[SYNC_STAGES-1];

  // count consecutive low samples, saturate, fire once per run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      evt_q     <= 1'b0;
    end else begin
      evt_q <= !lvl_s && (low_cnt_q == CNT_FIRE);
      if (lvl_s)                  low_cnt_q <= '0;
      else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign kick_evt_o = evt_q;

endmodule

// File: rtl/pkc_power_fsm.sv
module pkc_power_fsm
  import pkc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok,
  input  logic aux_en,
  input  logic kick_evt,
  input  logic wake,
  input  logic off_cmd,
  output logic pwr_on_o
);

  logic pwr_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_on_q <= 1'b0;
    else        pwr_on_q <= pkc_next_pwr(main_ok, aux_en, kick_evt, wake, off_cmd, pwr_on_q);
  end

  assign pwr_on_o = pwr_on_q;

endmodule

// File: rtl/pkc_host_regs.sv
module pkc_host_regs
  import pkc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              main_ok,
  input  logic              kick_evt,
  input  logic              pwr_on,
  output logic              aux_en_o,
  output logic              irq_en_o,
  output logic              off_cmd_o,
  output logic              flag_clr_o,
  output logic              flag_o
);

  logic [DATA_W-1:0] ctrl_q;
  logic              flag_q;
  logic              flag_set;

  assign off_cmd_o  = wr_en && (wr_addr == REG_CMD)  && wr_data[CMD_OFF_BIT];
  assign flag_clr_o = wr_en && (wr_addr == REG_FLAG) && wr_data[FLAG_KICK_BIT];
  assign flag_set   = kick_evt && main_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == REG_CTRL)) ctrl_q <= wr_data;
      flag_q <= pkc_next_flag(flag_set, flag_clr_o, flag_q);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: rd_data = ctrl_q;
      REG_CMD:  rd_data[CMD_OFF_BIT]   = pwr_on;
      REG_FLAG: rd_data[FLAG_KICK_BIT] = flag_q;
      default:  rd_data = '0;
    endcase
  end

  assign aux_en_o = ctrl_q[CTRL_AUX_BIT];
  assign irq_en_o = ctrl_q[CTRL_IRQEN_BIT];
  assign flag_o   = flag_q;

endmodule

// File: rtl/pwr_kick_ctrl.sv
module pwr_kick_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_pwr_ok,
  input  logic              kick_n,
  input  logic              wake_evt,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwr_en_n,
  output logic              irq_n
);

  // named internal events, visible to the bound checker
  logic kick_evt;
  logic aux_en;
  logic irq_en;
  logic off_cmd;
  logic flag_clr;
  logic kick_flag;
  logic pwr_on;

  pkc_kick_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_LEN    (DEB_LEN)
  ) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_n    (kick_n),
    .kick_evt_o(kick_evt)
  );

  pkc_host_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .main_ok   (main_pwr_ok),
    .kick_evt  (kick_evt),
    .pwr_on    (pwr_on),
    .aux_en_o  (aux_en),
    .irq_en_o  (irq_en),
    .off_cmd_o (off_cmd),
    .flag_clr_o(flag_clr),
    .flag_o    (kick_flag)
  );

  pkc_power_fsm u_power (
    .clk     (clk),
    .rst_n   (rst_n),
    .main_ok (main_pwr_ok),
    .aux_en  (aux_en),
    .kick_evt(kick_evt),
    .wake    (wake_evt),
    .off_cmd (off_cmd),
    .pwr_on_o(pwr_on)
  );

  assign pwr_en_n = ~pwr_on;
  assign irq_n    = ~(kick_flag & irq_en);

endmodule

// File: rtl/pkc_checker.sv
module pkc_checker (
  input logic clk,
  input logic rst_n,
  input logic main_ok,
  input logic wake,
  input logic aux_en,
  input logic kick_evt,
  input logic off_cmd,
  input logic flag_clr,
  input logic flag,
  input logic pwr_en_n,
  input logic irq_n
);

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> (pwr_en_n && irq_n));

  assert_aux_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_evt && !main_ok && !aux_en && !wake && pwr_en_n) |=> pwr_en_n);

  assert_wake_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !main_ok) |=> !pwr_en_n);

  assert_host_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cmd && main_ok) |=> pwr_en_n);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_evt && main_ok) |=> flag);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |=> !kick_evt);

endmodule

bind pwr_kick_ctrl pkc_checker u_pkc_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .main_ok (main_pwr_ok),
  .wake    (wake_evt),
  .aux_en  (aux_en),
  .kick_evt(kick_evt),
  .off_cmd (off_cmd),
  .flag_clr(flag_clr),
  .flag    (kick_flag),
  .pwr_en_n(pwr_en_n),
  .irq_n   (irq_n)
);

// File: tb/test_pwr_kick_ctrl.sv
module test_pwr_kick_ctrl;

  localparam int SYNC  = 2;
  localparam int DEB   = 4;
  localparam int DW    = 8;
  localparam int LAT   = DEB + SYNC + 1;   // press edges to power change

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          main_pwr_ok = 1'b0;
  logic          kick_n = 1'b1;
  logic          wake_evt = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          pwr_en_n;
  logic          irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  pwr_kick_ctrl #(.SYNC_STAGES(SYNC), .DEB_LEN(DEB), .DATA_W(DW)) i_pwr_kick_ctrl (
    .clk(clk), .rst_n(rst_n), .main_pwr_ok(main_pwr_ok), .kick_n(kick_n),
    .wake_evt(wake_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwr_en_n(pwr_en_n), .irq_n(irq_n)
  );

  // behavioural reference model
  bit m_pwr = 0, m_flag = 0, m_aux = 0, m_irqen = 0;
  int run = 0;
  int dq[$];

  initial for (int i = 0; i < SYNC + 1; i++) dq.push_back(0);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pwr = 0; m_flag = 0; m_aux = 0; m_irqen = 0; run = 0;
      dq.delete();
      for (int i = 0; i < SYNC + 1; i++) dq.push_back(0);
    end else begin
      int fire, eff;
      bit off, clr, npwr;
      fire = (!kick_n && run == DEB - 1) ? 1 : 0;
      run  = kick_n ? 0 : run + 1;
      dq.push_back(fire);
      eff  = dq.pop_front();
      off  = wr_en && wr_addr == 2'd1 && wr_data[0];
      clr  = wr_en && wr_addr == 2'd2 && wr_data[0];
      npwr = m_pwr;
      if (main_pwr_ok) begin
        if (off) npwr = 0;
      end else if ((eff != 0 && m_aux) || wake_evt) npwr = 1;
      if (eff != 0 && main_pwr_ok) m_flag = 1;
      else if (clr) m_flag = 0;
      m_pwr = npwr;
      if (wr_en && wr_addr == 2'd0) begin
        m_aux = wr_data[0]; m_irqen = wr_data[1];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (!done) begin
    chk("model pwr_en_n (R2,R5,R6)", {31'd0, pwr_en_n}, {31'd0, !m_pwr});
    chk("model irq_n (R9)", {31'd0, irq_n}, {31'd0, !(m_flag && m_irqen)});
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [1:0] a, logic [DW-1:0] exp, string tag);
    rd_addr = a;
    #1;
    chk(tag, {24'd0, rd_data}, {24'd0, exp});
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (all) actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    tick(3);
    chk("R1 pwr_en_n in reset", {31'd0, pwr_en_n}, 32'd1);
    rst_n = 1'b1;
    tick(1);
    chk("R1 pwr_en_n", {31'd0, pwr_en_n}, 32'd1);
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd2, 8'h00, "R1 flag");

    // R4: press with auxiliary enable clear, main absent
    kick_n = 1'b0; tick(LAT + 2); kick_n = 1'b1; tick(4);
    chk("R4 no power-on", {31'd0, pwr_en_n}, 32'd1);

    // R3: short glitch with auxiliary enable set
    wr(2'd0, 8'h01);
    kick_n = 1'b0; tick(DEB - 1); kick_n = 1'b1; tick(10);
    chk("R3 glitch ignored", {31'd0, pwr_en_n}, 32'd1);

    // R2: valid press, exact latency
    kick_n = 1'b0; tick(LAT - 1);
    chk("R2 not yet", {31'd0, pwr_en_n}, 32'd1);
    tick(1);
    chk("R2 power on", {31'd0, pwr_en_n}, 32'd0);
    rd(2'd1, 8'h01, "R11 cmd reads on");
    kick_n = 1'b1; tick(4);

    // R6: host owns power with main good
    main_pwr_ok = 1'b1; tick(2);
    wr(2'd1, 8'h01);
    chk("R6 host off", {31'd0, pwr_en_n}, 32'd1);
    rd(2'd1, 8'h00, "R11 cmd reads off");
    rd(2'd0, 8'h01, "R11 ctrl readback");
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0; tick(1);
    chk("R6 wake ignored with main", {31'd0, pwr_en_n}, 32'd1);

    // R7, R9, R10: kickstart as interrupt source
    kick_n = 1'b0; tick(LAT);
    chk("R6 press no power", {31'd0, pwr_en_n}, 32'd1);
    rd(2'd2, 8'h01, "R7 flag set");
    chk("R9 masked irq", {31'd0, irq_n}, 32'd1);
    wr(2'd0, 8'h03);
    chk("R9 irq asserted", {31'd0, irq_n}, 32'd0);
    tick(5);
    rd(2'd2, 8'h01, "R7 flag sticky");
    wr(2'd2, 8'h01);
    chk("R9 irq released", {31'd0, irq_n}, 32'd1);
    tick(10);
    rd(2'd2, 8'h00, "R10 held low no refire");
    kick_n = 1'b1; tick(3);

    // R8: clear lands on the edge of a new set
    kick_n = 1'b0; tick(LAT - 1);
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h01, "R8 set wins");
    chk("R8 irq", {31'd0, irq_n}, 32'd0);
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h00, "R7 cleared by host");
    kick_n = 1'b1; tick(3);

    // R5: wake with main absent, auxiliary enable clear
    wr(2'd0, 8'h00);
    main_pwr_ok = 1'b0; tick(3);
    chk("R6 off holds without main", {31'd0, pwr_en_n}, 32'd1);
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
    chk("R5 wake power on", {31'd0, pwr_en_n}, 32'd0);
    tick(3);
    finish_run();
  end

endmodule